// File: doc/BRIEF.md
# Vector Control Status Register File

This block keeps the control and status state of a vector unit and serves it through a single software port (address, write data, write enable, combinational read data). The fixed-point rounding mode and the saturation flag each exist once. They can be reached through their own addresses, and also through a combined view that packs both into one word. A write through any view updates the one shared copy, so every view stays consistent. The datapath raises the saturation flag with a one-cycle pulse, and the flag stays set until software writes it.

The start-index register accepts only values below the vector register width. A software write keeps the low bits that fit and raises a sticky illegal-write flag when bits above them were set. The vector length and vector type registers cannot be written by software. They are loaded only from a hardware update port. A parameter chooses whether those two registers reset to their recommended values or are left without a reset. Addresses that the block does not implement raise an illegal-access output and read as zero.

Top module: `vec_ctl_csr_file`

## Requirements
- R1: The combined view (address 0x00F) reads the rounding mode in bits 2:1 and the saturation flag in bit 0. All higher bits read zero.
- R2: A write to the combined view loads the rounding mode from write-data bits 2:1 and the saturation flag from bit 0. From the next cycle, the rounding view (0x00A) and the saturation view (0x009) return those values.
- R3: A write to the rounding view (0x00A) loads the rounding mode from write-data bits 1:0 and leaves the saturation flag unchanged. Reading the rounding view returns the rounding mode zero-extended to XLEN, and the `rnd_mode` output follows it.
- R4: A write to the saturation view (0x009) loads the flag from write-data bit 0 and leaves the rounding mode unchanged. The read is zero-extended.
- R5: A high `hw_sat_set` in a cycle sets the saturation flag at the next edge and keeps it set. A software write of the flag in the same cycle, through either view, takes priority.
- R6: A write to the start index (0x008) stores `wdata & (VLEN-1)`. At the same edge `start_bad` becomes 1 if `wdata >= VLEN` and 0 otherwise.
- R7: Software writes to the vector length (0xC20) and vector type (0xC21) have no effect. When `hw_cfg_we` is high, both registers load from `hw_vl` and `hw_vtype` at the next edge; otherwise they hold.
- R8: A vector type read places the illegal flag (`hw_vtype[8]`) at bit XLEN-1 and `hw_vtype[7:0]` at bits 7:0. Those low bits are, from bit 7 down: mask-agnostic, tail-agnostic, element-width code (3 bits) and length-multiplier code (3 bits). Bits XLEN-2:8 read zero.
- R9: After reset with `RESET_RECOMMENDED`=1, the vector length is 0 and the vector type reads with only the illegal flag set. The rounding mode, saturation flag, start index and `start_bad` are all 0.
- R10: For an address outside the six listed, `illegal_acc` is 1 in the same cycle, `csr_rdata` is 0, and a write changes no state. For the six listed addresses `illegal_acc` is 0.
- R11: `csr_rdata` is combinational on `csr_addr`. It shows the state before any write that happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Software write data |
| csr_we | input | 1 | Software write enable |
| csr_rdata | output | XLEN | Read data for `csr_addr` |
| illegal_acc | output | 1 | Address is not implemented |
| hw_sat_set | input | 1 | Saturation event pulse from the datapath |
| hw_cfg_we | input | 1 | Load vector length and type |
| hw_vl | input | VL_W | New vector length |
| hw_vtype | input | 9 | New type: {illegal, ma, ta, sew[2:0], lmul[2:0]} |
| rnd_mode | output | 2 | Current rounding mode |
| sat_flag | output | 1 | Current saturation flag |
| start_idx | output | START_W | Current start index |
| start_bad | output | 1 | Last start-index write was out of range |
| cur_vl | output | VL_W | Current vector length |
| cur_vtype | output | XLEN | Current vector type in register layout |

## Verification
A desynchronised alias is the main risk: a combined view that no longer matches the individual rounding or saturation view. That error shows on `csr_rdata` as soon as either address is read, one cycle after the write that split them. A wrong start-index mask or a wrong flag shows on `start_idx` and `start_bad` at the first edge after the write. A read-only register that software can change shows on `cur_vl` or `cur_vtype` in the cycle after the write. The reference model therefore compares every output after every edge, so a fault appears within one cycle of its cause.

// File: rtl/vcsr_pkg.sv
package vcsr_pkg;

   // Internal vector type state, stored in hw_vtype layout
   typedef struct packed {
      logic       ill;
      logic       ma;
      logic       ta;
      logic [2:0] sew;
      logic [2:0] lmul;
   } vshape_t;

   localparam int SHAPE_W = 9;

   // Recommended reset value: illegal set, all other fields zero
   localparam vshape_t SHAPE_RST = '{ill: 1'b1, ma: 1'b0, ta: 1'b0, sew: 3'd0, lmul: 3'd0};

   typedef enum logic [2:0] {
      SEL_START,
      SEL_SAT,
      SEL_RND,
      SEL_COMB,
      SEL_VL,
      SEL_VTYPE,
      SEL_NONE
   } csr_sel_e;

endpackage

// File: rtl/vcsr_fixpt.sv
module vcsr_fixpt (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rnd_we,
   input  logic       sat_we,
   input  logic [1:0] rnd_wval,
   input  logic       sat_wval,
   input  logic       hw_sat_set,
   output logic [1:0] rnd_q,
   output logic       sat_q
);

   logic sat_d;

   // Software write wins over a same-cycle hardware pulse
   always_comb begin
      if (sat_we) sat_d = sat_wval;
      else        sat_d = sat_q | hw_sat_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rnd_q <= 2'd0;
         sat_q <= 1'b0;
      end else begin
         if (rnd_we) rnd_q <= rnd_wval;
         sat_q <= sat_d;
      end
   end

endmodule

// File: rtl/vcsr_start.sv
module vcsr_start #(
   parameter int XLEN = 32,
   parameter int VLEN = 128,
   localparam int START_W = $clog2(VLEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [XLEN-1:0]    wdata,
   output logic [START_W-1:0] start_q,
   output logic               bad_q
);

   logic overflow;

   // Any set bit above the index field means the value does not fit
   assign overflow = |wdata[XLEN-1:START_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         bad_q   <= 1'b0;
      end else if (we) begin
         start_q <= wdata[START_W-1:0];
         bad_q   <= overflow;
      end
   end

endmodule

// File: rtl/vcsr_shape.sv
module vcsr_shape
   import vcsr_pkg::*;
#(
   parameter int VLEN = 128,
   parameter bit RESET_RECOMMENDED = 1'b1,
   localparam int VL_W = $clog2(VLEN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hw_we,
   input  logic [VL_W-1:0] hw_vl,
   input  vshape_t         hw_shape,
   output logic [VL_W-1:0] vl_q,
   output vshape_t         shape_q
);

   generate
      if (RESET_RECOMMENDED) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vl_q    <= '0;
               shape_q <= SHAPE_RST;
            end else if (hw_we) begin
               vl_q    <= hw_vl;
               shape_q <= hw_shape;
            end
         end
      end else begin : g_norst
         // Implementation-defined reset: the registers keep no reset
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (hw_we) begin
               vl_q    <= hw_vl;
               shape_q <= hw_shape;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/vec_ctl_csr_file.sv
module vec_ctl_csr_file
   import vcsr_pkg::*;
#(
   parameter int          XLEN = 32,
   parameter int          VLEN = 128,
   parameter bit          RESET_RECOMMENDED = 1'b1,
   parameter logic [11:0] ADDR_START = 12'h008,
   parameter logic [11:0] ADDR_SAT   = 12'h009,
   parameter logic [11:0] ADDR_RND   = 12'h00A,
   parameter logic [11:0] ADDR_COMB  = 12'h00F,
   parameter logic [11:0] ADDR_VL    = 12'hC20,
   parameter logic [11:0] ADDR_VTYPE = 12'hC21,
   localparam int START_W = $clog2(VLEN),
   localparam int VL_W    = $clog2(VLEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [11:0]        csr_addr,
   input  logic [XLEN-1:0]    csr_wdata,
   input  logic               csr_we,
   output logic [XLEN-1:0]    csr_rdata,
   output logic               illegal_acc,
   input  logic               hw_sat_set,
   input  logic               hw_cfg_we,
   input  logic [VL_W-1:0]    hw_vl,
   input  logic [SHAPE_W-1:0] hw_vtype,
   output logic [1:0]         rnd_mode,
   output logic               sat_flag,
   output logic [START_W-1:0] start_idx,
   output logic               start_bad,
   output logic [VL_W-1:0]    cur_vl,
   output logic [XLEN-1:0]    cur_vtype
);

   // Elaboration-time parameter checks
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("XLEN must be 32 or 64");
      end
      if (VLEN < 8 || VLEN > 65536 || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
         $error("VLEN must be a power of two in 8..65536");
      end
      if (VL_W >= XLEN) begin : g_bad_vlw
         $error("vector length does not fit in XLEN");
      end
   endgenerate

   csr_sel_e        sel;
   vshape_t         shape_q;
   logic [VL_W-1:0] vl_q;

   // Address decode
   always_comb begin
      unique case (csr_addr)
         ADDR_START: sel = SEL_START;
         ADDR_SAT:   sel = SEL_SAT;
         ADDR_RND:   sel = SEL_RND;
         ADDR_COMB:  sel = SEL_COMB;
         ADDR_VL:    sel = SEL_VL;
         ADDR_VTYPE: sel = SEL_VTYPE;
         default:    sel = SEL_NONE;
      endcase
   end

   assign illegal_acc = (sel == SEL_NONE);

   logic wr_rnd, wr_sat, wr_start;
   logic [1:0] rnd_wval;

   assign wr_rnd   = csr_we && (sel == SEL_RND || sel == SEL_COMB);
   assign wr_sat   = csr_we && (sel == SEL_SAT || sel == SEL_COMB);
   assign wr_start = csr_we && (sel == SEL_START);
   assign rnd_wval = (sel == SEL_COMB) ? csr_wdata[2:1] : csr_wdata[1:0];

   vcsr_fixpt u_fixpt (
      .clk        (clk),
      .rst_n      (rst_n),
      .rnd_we     (wr_rnd),
      .sat_we     (wr_sat),
      .rnd_wval   (rnd_wval),
      .sat_wval   (csr_wdata[0]),
      .hw_sat_set (hw_sat_set),
      .rnd_q      (rnd_mode),
      .sat_q      (sat_flag)
   );

   vcsr_start #(.XLEN(XLEN), .VLEN(VLEN)) u_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_start),
      .wdata   (csr_wdata),
      .start_q (start_idx),
      .bad_q   (start_bad)
   );

   vcsr_shape #(.VLEN(VLEN), .RESET_RECOMMENDED(RESET_RECOMMENDED)) u_shape (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_we    (hw_cfg_we),
      .hw_vl    (hw_vl),
      .hw_shape (vshape_t'(hw_vtype)),
      .vl_q     (vl_q),
      .shape_q  (shape_q)
   );

   assign cur_vl    = vl_q;
   assign cur_vtype = {shape_q.ill, {(XLEN-SHAPE_W){1'b0}},
                       shape_q.ma, shape_q.ta, shape_q.sew, shape_q.lmul};

   // Read mux shows state before any same-cycle write
   always_comb begin
      csr_rdata = '0;
      unique case (sel)
         SEL_START: csr_rdata[START_W-1:0] = start_idx;
         SEL_SAT:   csr_rdata[0]           = sat_flag;
         SEL_RND:   csr_rdata[1:0]         = rnd_mode;
         SEL_COMB:  csr_rdata[2:0]         = {rnd_mode, sat_flag};
         SEL_VL:    csr_rdata[VL_W-1:0]    = vl_q;
         SEL_VTYPE: csr_rdata              = cur_vtype;
         default:   csr_rdata              = '0;
      endcase
   end

endmodule

// File: rtl/vec_ctl_csr_chk.sv
module vec_ctl_csr_chk #(
   parameter int          XLEN = 32,
   parameter int          VLEN = 128,
   parameter logic [11:0] ADDR_START = 12'h008,
   parameter logic [11:0] ADDR_SAT   = 12'h009,
   parameter logic [11:0] ADDR_COMB  = 12'h00F,
   localparam int START_W = $clog2(VLEN),
   localparam int VL_W    = $clog2(VLEN + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [11:0]        csr_addr,
   input logic [XLEN-1:0]    csr_wdata,
   input logic               csr_we,
   input logic [XLEN-1:0]    csr_rdata,
   input logic               illegal_acc,
   input logic               hw_sat_set,
   input logic               hw_cfg_we,
   input logic [1:0]         rnd_mode,
   input logic               sat_flag,
   input logic [START_W-1:0] start_idx,
   input logic               start_bad,
   input logic [VL_W-1:0]    cur_vl,
   input logic [XLEN-1:0]    cur_vtype
);

   logic sw_sat;
   assign sw_sat = csr_we && (csr_addr == ADDR_SAT || csr_addr == ADDR_COMB);

   AST_COMB_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == ADDR_COMB) |-> (csr_rdata == {{(XLEN-3){1'b0}}, rnd_mode, sat_flag})); // R1

   AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_sat_set && !sw_sat) |=> sat_flag); // R5

   AST_SAT_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_sat |=> (sat_flag == $past(csr_wdata[0]))); // R5

   AST_START_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_addr == ADDR_START) |=>
         (start_idx == $past(csr_wdata[START_W-1:0]))); // R6

   AST_START_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_addr == ADDR_START) |=>
         (start_bad == ($past(csr_wdata) >= XLEN'(VLEN)))); // R6

   AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_cfg_we |=> ($stable(cur_vl) && $stable(cur_vtype))); // R7

   AST_VTYPE_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_vtype[XLEN-2:8] == '0)); // R8

   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_acc |-> (csr_rdata == '0)); // R10

endmodule

bind vec_ctl_csr_file vec_ctl_csr_chk #(
   .XLEN(XLEN), .VLEN(VLEN),
   .ADDR_START(ADDR_START), .ADDR_SAT(ADDR_SAT), .ADDR_COMB(ADDR_COMB)
) u_chk (.*);

// File: tb/vec_ctl_csr_file_tb.sv
module vec_ctl_csr_file_tb;

   localparam int XLEN = 32;
   localparam int VLEN = 128;
   localparam int SW   = 7;
   localparam int VW   = 8;
   localparam logic [11:0] A_START = 12'h008, A_SAT = 12'h009, A_RND = 12'h00A,
                           A_COMB = 12'h00F, A_VL = 12'hC20, A_VT = 12'hC21;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [11:0]     csr_addr = '0;
   logic [XLEN-1:0] csr_wdata = '0;
   logic            csr_we = 1'b0;
   logic [XLEN-1:0] csr_rdata;
   logic            illegal_acc;
   logic            hw_sat_set = 1'b0;
   logic            hw_cfg_we = 1'b0;
   logic [VW-1:0]   hw_vl = '0;
   logic [8:0]      hw_vtype = '0;
   logic [1:0]      rnd_mode;
   logic            sat_flag;
   logic [SW-1:0]   start_idx;
   logic            start_bad;
   logic [VW-1:0]   cur_vl;
   logic [XLEN-1:0] cur_vtype;

   always #2 clk = ~clk;

   vec_ctl_csr_file #(.XLEN(XLEN), .VLEN(VLEN)) u_dut (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // Reference model state
   logic [1:0]      m_rnd;
   logic            m_sat;
   logic [31:0]     m_start;
   logic            m_bad;
   logic [31:0]     m_vl;
   logic            m_ill;
   logic [7:0]      m_vt;

   function automatic logic [31:0] m_vtype();
      return {m_ill, 23'd0, m_vt};
   endfunction

   function automatic bit m_known(logic [11:0] a);
      return a == A_START || a == A_SAT || a == A_RND || a == A_COMB || a == A_VL || a == A_VT;
   endfunction

   function automatic logic [31:0] m_read(logic [11:0] a);
      if (a == A_START) return m_start;
      if (a == A_SAT)   return {31'd0, m_sat};
      if (a == A_RND)   return {30'd0, m_rnd};
      if (a == A_COMB)  return {29'd0, m_rnd, m_sat};
      if (a == A_VL)    return m_vl;
      if (a == A_VT)    return m_vtype();
      return 32'd0;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: drive inputs, compare all outputs, then advance model at edge
   task automatic cyc(logic [11:0] a, logic [31:0] d, logic we, logic hs,
                      logic hwe, logic [7:0] hvl, logic [8:0] hvt, string tag);
      csr_addr = a; csr_wdata = d; csr_we = we; hw_sat_set = hs;
      hw_cfg_we = hwe; hw_vl = hvl; hw_vtype = hvt;
      #1;
      check({tag, " rdata"}, csr_rdata, m_read(a));
      check("R10 illegal_acc", {31'd0, illegal_acc}, {31'd0, !m_known(a)});
      check("R3 rnd_mode", {30'd0, rnd_mode}, {30'd0, m_rnd});
      check("R5 sat_flag", {31'd0, sat_flag}, {31'd0, m_sat});
      check("R6 start_idx", {25'd0, start_idx}, m_start);
      check("R6 start_bad", {31'd0, start_bad}, {31'd0, m_bad});
      check("R7 cur_vl", {24'd0, cur_vl}, m_vl);
      check("R8 cur_vtype", cur_vtype, m_vtype());
      @(posedge clk);
      if (we && a == A_START) begin m_start = d & 32'(VLEN - 1); m_bad = (d >= 32'(VLEN)); end
      if (we && a == A_RND)   m_rnd = d[1:0];
      if (we && a == A_COMB)  m_rnd = d[2:1];
      if (we && (a == A_SAT || a == A_COMB)) m_sat = d[0];
      else if (hs) m_sat = 1'b1;
      if (hwe) begin m_vl = {24'd0, hvl}; m_ill = hvt[8]; m_vt = hvt[7:0]; end
      @(negedge clk);
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] lit, string tag);
      csr_addr = a; csr_we = 1'b0;
      #1;
      check({tag, " literal"}, csr_rdata, lit);
      cyc(a, 32'd0, 1'b0, 1'b0, 1'b0, 8'd0, 9'd0, tag);
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
      cyc(a, d, 1'b1, 1'b0, 1'b0, 8'd0, 9'd0, tag);
   endtask

   initial begin
      m_rnd = 0; m_sat = 0; m_start = 0; m_bad = 0; m_vl = 0; m_ill = 1; m_vt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      rd(A_VL, 32'd0, "R9");
      rd(A_VT, 32'h8000_0000, "R9");
      rd(A_COMB, 32'd0, "R9");
      rd(A_START, 32'd0, "R9");
      // R1 / R2 combined write
      wr(A_COMB, 32'hFFFF_FFF5, "R2");
      rd(A_COMB, 32'h5, "R1");
      rd(A_RND, 32'h2, "R2");
      rd(A_SAT, 32'h1, "R2");
      // R3 rounding view write, sat unchanged
      wr(A_RND, 32'hFFFF_FFF1, "R3");
      rd(A_COMB, 32'h3, "R3");
      // R4 saturation view write
      wr(A_SAT, 32'h0, "R4");
      rd(A_COMB, 32'h2, "R4");
      // R5 hw pulse sticky, then sw write wins
      cyc(A_RND, 0, 1'b0, 1'b1, 1'b0, 8'd0, 9'd0, "R5");
      rd(A_SAT, 32'h1, "R5");
      cyc(A_SAT, 0, 1'b1, 1'b1, 1'b0, 8'd0, 9'd0, "R5");
      rd(A_SAT, 32'h0, "R5");
      // R11 read during write shows old value
      csr_addr = A_RND; csr_wdata = 32'h3; csr_we = 1'b1; #1;
      check("R11 pre-write read", csr_rdata, 32'h1);
      cyc(A_RND, 32'h3, 1'b1, 1'b0, 1'b0, 8'd0, 9'd0, "R11");
      // R6 start index
      wr(A_START, 32'd5, "R6");   rd(A_START, 32'd5, "R6");
      wr(A_START, 32'd127, "R6"); rd(A_START, 32'd127, "R6");
      wr(A_START, 32'd128, "R6"); rd(A_START, 32'd0, "R6");
      wr(A_START, 32'd200, "R6"); rd(A_START, 32'd72, "R6");
      wr(A_START, 32'd3, "R6");   rd(A_START, 32'd3, "R6");
      // R7 read-only registers
      wr(A_VL, 32'd77, "R7"); wr(A_VT, 32'd0, "R7");
      rd(A_VL, 32'd0, "R7");  rd(A_VT, 32'h8000_0000, "R7");
      cyc(A_VL, 0, 1'b0, 1'b0, 1'b1, 8'd128, 9'b0_1001_1001, "R7");
      rd(A_VL, 32'd128, "R7");
      rd(A_VT, 32'h0000_0099, "R8");
      // R10 unimplemented address
      wr(12'h123, 32'hFFFF_FFFF, "R10");
      rd(12'h123, 32'd0, "R10");
      rd(A_COMB, {29'd0, m_rnd, m_sat}, "R10");
      // Mixed traffic
      for (int i = 0; i < 400; i++) begin
         logic [11:0] a;
         logic [31:0] r;
         r = $urandom;
         case (r[2:0])
            3'd0: a = A_START; 3'd1: a = A_SAT; 3'd2: a = A_RND; 3'd3: a = A_COMB;
            3'd4: a = A_VL;    3'd5: a = A_VT;  default: a = 12'(r[31:20]);
         endcase
         cyc(a, (r[3] ? 32'($urandom) : 32'($urandom_range(0, 255))), r[4], r[5] & r[6],
             r[7] & r[8], 8'($urandom), 9'($urandom), "R11");
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule